// File: doc/BRIEF.md
# Logic analyzer configuration command decoder

This block sits behind a UART receiver and turns the incoming byte stream into configuration state for a logic-analyzer capture engine. Each byte is an opcode or an argument. An opcode with bit 7 clear is a one-byte command that raises a single-cycle strobe. An opcode with bit 7 set opens a five-byte command. That command carries a 32-bit argument, sent low byte first, which is written into the register it selects. The registers hold the per-stage trigger mask, value and configuration words, a 24-bit sample clock divider, the read and delay counts, and a 16-bit flag word. A vector of channel-group enables is derived from the flag word.

An identify request makes the block return a fixed four-byte signature over a byte-wide valid/ready transmit port. Because every long command consumes at most four argument bytes, five zero bytes in a row always return the parser to its idle state, whatever partial command it held. A host uses this to resynchronise before it issues a command.

Top module: `la_cmd_decoder`

## Requirements
- R1: After rst_ni is released and before any byte arrives, all strobes are low, wr_valid_o and tx_valid_o are low, every register reads zero and grp_en_o is 4'b1111.
- R2: In idle, a byte with bit 7 clear is a short command. 0x00 pulses reset_o, 0x01 pulses run_o, 0x02 pulses id_o and 0x04 pulses meta_o. Each pulse lasts one cycle and starts in the cycle after the byte is accepted. Any other short opcode produces no strobe.
- R3: A byte with bit 7 set starts a long command, followed by four argument bytes, least significant first. The register write is visible in the cycle after the fifth byte. In that same cycle wr_valid_o is high for one cycle and wr_op_o holds the opcode.
- R4: For stage n < NUM_STAGES, opcode 0xC0+4n writes the trigger mask, 0xC1+4n the trigger value and 0xC2+4n the trigger configuration. Stage n occupies bits [32n+31:32n] of the matching output.
- R5: Opcode 0x80 loads divider_o from argument bits [23:0]. The fourth argument byte is ignored.
- R6: Opcode 0x81 loads read_cnt_o from argument bits [15:0] and delay_cnt_o from bits [31:16].
- R7: Opcode 0x82 loads flags_o from argument bits [15:0]. grp_en_o[i] is the inverse of flags_o[2+i] for i = 0..3.
- R8: A long opcode that selects no register consumes its four argument bytes. This covers a stage at or above NUM_STAGES, low opcode bits 2'b11 in the stage range, and any other unused code. It changes no register and raises no wr_valid_o.
- R9: After five consecutive zero bytes, the parser is idle whatever it held before, so the next byte is decoded as an opcode.
- R10: id_o also starts transmission of SIGNATURE, most significant byte first, one byte per tx_valid_o/tx_ready_i handshake. tx_data_o holds while tx_ready_i is low. A new identify restarts from the first byte.
- R11: Bytes in argument positions never raise a short-command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| reset_o | output | 1 | Reset command strobe |
| run_o | output | 1 | Run command strobe |
| id_o | output | 1 | Identify command strobe |
| meta_o | output | 1 | Metadata request strobe |
| wr_valid_o | output | 1 | Register write strobe |
| wr_op_o | output | 8 | Opcode of the register just written |
| trig_mask_o | output | 32*NUM_STAGES | Trigger masks, stage 0 in the low word |
| trig_value_o | output | 32*NUM_STAGES | Trigger values |
| trig_cfg_o | output | 32*NUM_STAGES | Trigger configuration words |
| divider_o | output | 24 | Sample clock divider |
| read_cnt_o | output | 16 | Read count minus one |
| delay_cnt_o | output | 16 | Delay count minus one |
| flags_o | output | 16 | Flag word |
| grp_en_o | output | 4 | Channel-group enables |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmit sink ready |

## Verification
The assertions are checked on every cycle. They cover the following:
- Every strobe traces back to a byte accepted in the previous cycle, and at most one strobe or write fires per cycle.
- A stalled transmit byte holds still.
- A run opcode that follows five zero bytes is always honoured.

Only the bench's scenarios can show the data-dependent results. These are which register an opcode reaches, the argument byte order, the discarding of unknown long opcodes, argument bytes that mimic short opcodes, and the full signature sequence under an irregular ready pattern with a restart partway through.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_ID    = 8'h02;
  localparam logic [7:0] OP_META  = 8'h04;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_SIZE  = 8'h81;
  localparam logic [7:0] OP_FLAGS = 8'h82;
  localparam int unsigned ARG_BYTES = 4;

  typedef struct packed {
    logic [7:0]  op;
    logic [31:0] arg;
  } long_cmd_t;
endpackage

// File: rtl/la_cmd_parser.sv
module la_cmd_parser
  import la_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       short_vld_o,
  output logic [7:0] short_op_o,
  output logic       long_vld_o,
  output long_cmd_t  long_cmd_o
);
  localparam int unsigned CW = $clog2(ARG_BYTES + 1);

  logic [CW-1:0] cnt_q;
  logic [7:0]    op_q;
  logic [23:0]   args_q;

  always_comb begin
    short_vld_o    = rx_valid_i && (cnt_q == '0) && !rx_data_i[7];
    short_op_o     = rx_data_i;
    long_vld_o     = rx_valid_i && (cnt_q == CW'(ARG_BYTES));
    long_cmd_o.op  = op_q;
    long_cmd_o.arg = {rx_data_i, args_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      op_q   <= '0;
      args_q <= '0;
    end else if (rx_valid_i) begin
      if (cnt_q == '0) begin
        if (rx_data_i[7]) begin
          op_q  <= rx_data_i;
          cnt_q <= CW'(1);
        end
      end else if (cnt_q == CW'(ARG_BYTES)) begin
        cnt_q <= '0;
      end else begin
        case (cnt_q)
          CW'(1):  args_q[7:0]   <= rx_data_i;
          CW'(2):  args_q[15:8]  <= rx_data_i;
          default: args_q[23:16] <= rx_data_i;
        endcase
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/la_cfg_regs.sv
module la_cfg_regs
  import la_cmd_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_vld_i,
  input  long_cmd_t               cmd_i,
  output logic                    wr_valid_o,
  output logic [7:0]              wr_op_o,
  output logic [32*NUM_STAGES-1:0] trig_mask_o,
  output logic [32*NUM_STAGES-1:0] trig_value_o,
  output logic [32*NUM_STAGES-1:0] trig_cfg_o,
  output logic [23:0]             divider_o,
  output logic [15:0]             read_cnt_o,
  output logic [15:0]             delay_cnt_o,
  output logic [15:0]             flags_o
);
  localparam int unsigned SEL_W = 4;

  logic              stage_grp;
  logic [NUM_STAGES-1:0] stage_hit;
  logic              hit_div, hit_size, hit_flags, known;

  assign stage_grp = (cmd_i.op[7:6] == 2'b11) && (cmd_i.op[1:0] != 2'b11);
  assign hit_div   = cmd_i.op == OP_DIV;
  assign hit_size  = cmd_i.op == OP_SIZE;
  assign hit_flags = cmd_i.op == OP_FLAGS;
  assign known     = hit_div || hit_size || hit_flags || (|stage_hit);

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic sel;
    assign sel          = stage_grp && (cmd_i.op[5:2] == SEL_W'(s));
    assign stage_hit[s] = sel;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        trig_mask_o[32*s +: 32]  <= '0;
        trig_value_o[32*s +: 32] <= '0;
        trig_cfg_o[32*s +: 32]   <= '0;
      end else if (cmd_vld_i && sel) begin
        case (cmd_i.op[1:0])
          2'b00:   trig_mask_o[32*s +: 32]  <= cmd_i.arg;
          2'b01:   trig_value_o[32*s +: 32] <= cmd_i.arg;
          default: trig_cfg_o[32*s +: 32]   <= cmd_i.arg;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      divider_o   <= '0;
      read_cnt_o  <= '0;
      delay_cnt_o <= '0;
      flags_o     <= '0;
      wr_valid_o  <= 1'b0;
      wr_op_o     <= '0;
    end else begin
      wr_valid_o <= cmd_vld_i && known;
      if (cmd_vld_i && known) wr_op_o <= cmd_i.op;
      if (cmd_vld_i && hit_div) divider_o <= cmd_i.arg[23:0];
      if (cmd_vld_i && hit_size) begin
        read_cnt_o  <= cmd_i.arg[15:0];
        delay_cnt_o <= cmd_i.arg[31:16];
      end
      if (cmd_vld_i && hit_flags) flags_o <= cmd_i.arg[15:0];
    end
  end
endmodule

// File: rtl/la_id_tx.sv
module la_id_tx #(
  parameter logic [31:0] SIGNATURE = 32'h4C413031
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o
);
  localparam int unsigned NB = 4;
  localparam int unsigned CW = $clog2(NB + 1);

  logic [31:0]   sh_q;
  logic [CW-1:0] left_q;

  assign tx_valid_o = left_q != '0;
  assign tx_data_o  = sh_q[31:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (start_i) begin
      sh_q   <= SIGNATURE;
      left_q <= CW'(NB);
    end else if (tx_valid_o && tx_ready_i) begin
      sh_q   <= {sh_q[23:0], 8'h00};
      left_q <= left_q - CW'(1);
    end
  end
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
  import la_cmd_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter logic [31:0] SIGNATURE  = 32'h4C413031
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_valid_i,
  input  logic [7:0]               rx_data_i,
  output logic                     reset_o,
  output logic                     run_o,
  output logic                     id_o,
  output logic                     meta_o,
  output logic                     wr_valid_o,
  output logic [7:0]               wr_op_o,
  output logic [32*NUM_STAGES-1:0] trig_mask_o,
  output logic [32*NUM_STAGES-1:0] trig_value_o,
  output logic [32*NUM_STAGES-1:0] trig_cfg_o,
  output logic [23:0]              divider_o,
  output logic [15:0]              read_cnt_o,
  output logic [15:0]              delay_cnt_o,
  output logic [15:0]              flags_o,
  output logic [3:0]               grp_en_o,
  output logic                     tx_valid_o,
  output logic [7:0]               tx_data_o,
  input  logic                     tx_ready_i
);
  localparam int unsigned GRP_LSB = 2;

  logic       short_vld, long_vld;
  logic [7:0] short_op;
  long_cmd_t  long_cmd;

  la_cmd_parser u_parser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .short_vld_o (short_vld),
    .short_op_o  (short_op),
    .long_vld_o  (long_vld),
    .long_cmd_o  (long_cmd)
  );

  la_cfg_regs #(.NUM_STAGES(NUM_STAGES)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_vld_i    (long_vld),
    .cmd_i        (long_cmd),
    .wr_valid_o   (wr_valid_o),
    .wr_op_o      (wr_op_o),
    .trig_mask_o  (trig_mask_o),
    .trig_value_o (trig_value_o),
    .trig_cfg_o   (trig_cfg_o),
    .divider_o    (divider_o),
    .read_cnt_o   (read_cnt_o),
    .delay_cnt_o  (delay_cnt_o),
    .flags_o      (flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_o <= 1'b0;
      run_o   <= 1'b0;
      id_o    <= 1'b0;
      meta_o  <= 1'b0;
    end else begin
      reset_o <= short_vld && (short_op == OP_RESET);
      run_o   <= short_vld && (short_op == OP_RUN);
      id_o    <= short_vld && (short_op == OP_ID);
      meta_o  <= short_vld && (short_op == OP_META);
    end
  end

  // transmitter loads on the same edge that raises id_o
  la_id_tx #(.SIGNATURE(SIGNATURE)) u_id_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (short_vld && (short_op == OP_ID)),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  // flag bit set means the group is disabled
  assign grp_en_o = ~flags_o[GRP_LSB +: 4];
endmodule

// File: rtl/la_cmd_decoder_chk.sv
module la_cmd_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       reset_o,
  input logic       run_o,
  input logic       id_o,
  input logic       meta_o,
  input logic       wr_valid_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i
);
  logic [2:0] zero_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zero_run <= '0;
    else if (rx_valid_i) begin
      if (rx_data_i != 8'h00) zero_run <= '0;
      else if (zero_run != 3'd5) zero_run <= zero_run + 3'd1;
    end
  end

  p_reset_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> ($past(rx_valid_i) && $past(rx_data_i) == 8'h00));

  p_run_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> ($past(rx_valid_i) && $past(rx_data_i) == 8'h01));

  p_one_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reset_o, run_o, id_o, meta_o, wr_valid_o}));

  p_wr_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(rx_valid_i));

  p_resync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_run == 3'd5 && rx_valid_i && rx_data_i == 8'h01) |=> run_o);

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> tx_valid_o);

  p_tx_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> ($stable(tx_data_o) || id_o));
endmodule

bind la_cmd_decoder la_cmd_decoder_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_data_i  (rx_data_i),
  .reset_o    (reset_o),
  .run_o      (run_o),
  .id_o       (id_o),
  .meta_o     (meta_o),
  .wr_valid_o (wr_valid_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_ready_i (tx_ready_i)
);

// File: tb/test_la_cmd_decoder.sv
module test_la_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam logic [31:0] SIG = 32'h4C413031;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic reset_s, run_s, id_s, meta_s, wr_valid, tx_valid;
  logic [7:0] wr_op, tx_data;
  logic [32*NS-1:0] t_mask, t_value, t_cfg;
  logic [23:0] divider;
  logic [15:0] read_cnt, delay_cnt, flags;
  logic [3:0] grp_en;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  la_cmd_decoder #(.NUM_STAGES(NS), .SIGNATURE(SIG)) i_la_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .reset_o(reset_s), .run_o(run_s), .id_o(id_s), .meta_o(meta_s),
    .wr_valid_o(wr_valid), .wr_op_o(wr_op),
    .trig_mask_o(t_mask), .trig_value_o(t_value), .trig_cfg_o(t_cfg),
    .divider_o(divider), .read_cnt_o(read_cnt), .delay_cnt_o(delay_cnt),
    .flags_o(flags), .grp_en_o(grp_en),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0]  q[$];
  logic [31:0] m_mask[NS], m_value[NS], m_cfg[NS];
  logic [23:0] m_div;
  logic [15:0] m_rd, m_dl, m_flags;
  logic m_rst, m_run, m_id, m_meta, m_wr, m_txv;
  logic [7:0] m_wr_op;
  int m_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      for (int s = 0; s < NS; s++) begin m_mask[s] = 0; m_value[s] = 0; m_cfg[s] = 0; end
      m_div = 0; m_rd = 0; m_dl = 0; m_flags = 0;
      {m_rst, m_run, m_id, m_meta, m_wr, m_txv} = '0;
      m_wr_op = 0; m_idx = 0;
    end else begin
      logic start;
      start = 1'b0;
      {m_rst, m_run, m_id, m_meta, m_wr} = '0;
      if (m_txv && tx_ready) begin
        m_idx++;
        if (m_idx == 4) m_txv = 1'b0;
      end
      if (rx_valid) begin
        if (q.size() == 0) begin
          if (rx_data >= 8'h80) q.push_back(rx_data);
          else if (rx_data == 8'h00) m_rst = 1'b1;
          else if (rx_data == 8'h01) m_run = 1'b1;
          else if (rx_data == 8'h02) begin m_id = 1'b1; start = 1'b1; end
          else if (rx_data == 8'h04) m_meta = 1'b1;
        end else begin
          q.push_back(rx_data);
          if (q.size() == 5) begin
            logic [7:0] op;
            logic [31:0] arg;
            op = q[0];
            arg = {q[4], q[3], q[2], q[1]};
            q.delete();
            if (op >= 8'hC0) begin
              int st, kd;
              st = (op - 8'hC0) / 4;
              kd = (op - 8'hC0) % 4;
              if (st < NS && kd < 3) begin
                m_wr = 1'b1;
                if (kd == 0) m_mask[st] = arg;
                else if (kd == 1) m_value[st] = arg;
                else m_cfg[st] = arg;
              end
            end else if (op == 8'h80) begin m_wr = 1'b1; m_div = arg[23:0]; end
            else if (op == 8'h81) begin m_wr = 1'b1; m_rd = arg[15:0]; m_dl = arg[31:16]; end
            else if (op == 8'h82) begin m_wr = 1'b1; m_flags = arg[15:0]; end
            if (m_wr) m_wr_op = op;
          end
        end
      end
      if (start) begin m_txv = 1'b1; m_idx = 0; end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    tx_ready = (cyc % 3) != 2;
    if (rst_n) begin
      chk(reset_s == m_rst, "R2 reset_o", reset_s, m_rst);
      chk(run_s == m_run, "R2 run_o", run_s, m_run);
      chk(id_s == m_id, "R2 id_o", id_s, m_id);
      chk(meta_s == m_meta, "R2 meta_o", meta_s, m_meta);
      chk(wr_valid == m_wr, "R3 wr_valid_o", wr_valid, m_wr);
      if (m_wr) chk(wr_op == m_wr_op, "R3 wr_op_o", wr_op, m_wr_op);
      for (int s = 0; s < NS; s++) begin
        chk(t_mask[32*s +: 32] == m_mask[s], "R4 trig mask", t_mask[32*s +: 32], m_mask[s]);
        chk(t_value[32*s +: 32] == m_value[s], "R4 trig value", t_value[32*s +: 32], m_value[s]);
        chk(t_cfg[32*s +: 32] == m_cfg[s], "R4 trig cfg", t_cfg[32*s +: 32], m_cfg[s]);
      end
      chk(divider == m_div, "R5 divider", divider, m_div);
      chk(read_cnt == m_rd, "R6 read count", read_cnt, m_rd);
      chk(delay_cnt == m_dl, "R6 delay count", delay_cnt, m_dl);
      chk(flags == m_flags, "R7 flags", flags, m_flags);
      chk(grp_en == ~m_flags[5:2], "R7 group enables", grp_en, ~m_flags[5:2]);
      chk(tx_valid == m_txv, "R10 tx_valid_o", tx_valid, m_txv);
      if (m_txv) chk(tx_data == SIG[31-8*m_idx -: 8], "R10 tx_data_o", tx_data, SIG[31-8*m_idx -: 8]);
    end
  end

  // call at a falling edge; returns at the next one with the result visible
  task automatic send_b(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
    send_b(op);
    for (int i = 0; i < 4; i++) send_b(arg[8*i +: 8]);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [23:0] div_keep;
    logic [15:0] flg_keep;
    logic [31:0] msk_keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({reset_s, run_s, id_s, meta_s, wr_valid, tx_valid} == 0, "R1 strobes idle", {reset_s, run_s, id_s, meta_s, wr_valid, tx_valid}, 0);
    chk(divider == 0 && flags == 0 && read_cnt == 0 && delay_cnt == 0, "R1 registers zero", {divider, flags}, 0);
    chk(t_mask == 0 && t_value == 0 && t_cfg == 0, "R1 trigger regs zero", t_mask[63:0], 0);
    chk(grp_en == 4'hF, "R1 groups enabled", grp_en, 4'hF);

    // R2 short commands, including unknown ones
    send_b(8'h01); send_b(8'h04); send_b(8'h03); send_b(8'h7F); send_b(8'h00);
    send_b(8'h02);
    repeat (12) @(negedge clk);

    // R10 identify restart mid-transfer
    send_b(8'h02); @(negedge clk); send_b(8'h02);
    repeat (12) @(negedge clk);

    // R5 / R6 / R7 register writes
    send_long(8'h80, 32'h44332211);
    chk(divider == 24'h332211, "R5 divider top byte ignored", divider, 24'h332211);
    send_long(8'h81, 32'hBEEF1234);
    chk(read_cnt == 16'h1234 && delay_cnt == 16'hBEEF, "R6 capture fields", {delay_cnt, read_cnt}, 32'hBEEF1234);
    send_long(8'h82, 32'hFFFF0024);
    chk(grp_en == 4'b0110, "R7 groups 0 and 3 disabled", grp_en, 4'b0110);

    // R4 every stage and kind
    for (int s = 0; s < NS; s++) begin
      send_long(8'hC0 + 8'(4*s), 32'hA0000000 + s);
      send_long(8'hC1 + 8'(4*s), 32'hB0000000 + s);
      send_long(8'hC2 + 8'(4*s), 32'hC0000000 + s);
    end

    // R8 unknown long opcodes
    div_keep = divider; flg_keep = flags; msk_keep = t_mask[31:0];
    send_long(8'hC3, 32'h11111111);
    send_long(8'hD0, 32'h22222222);
    send_long(8'h85, 32'h33333333);
    send_long(8'hFF, 32'h44444444);
    chk(divider == div_keep && flags == flg_keep && t_mask[31:0] == msk_keep, "R8 no register changed", divider, div_keep);
    send_b(8'h01);
    chk(run_s == 1'b1, "R8 four args consumed, next byte is opcode", run_s, 1);

    // R9 resync from a partial long command
    send_b(8'h80); send_b(8'hAA);
    for (int i = 0; i < 5; i++) send_b(8'h00);
    send_b(8'h01);
    chk(run_s == 1'b1, "R9 run after five zeros", run_s, 1);
    send_b(8'hC1); send_b(8'h55); send_b(8'h66);
    for (int i = 0; i < 5; i++) send_b(8'h00);
    send_b(8'h04);
    chk(meta_s == 1'b1, "R9 meta after five zeros", meta_s, 1);

    // R11 short opcodes in argument positions
    send_b(8'h80);
    for (int i = 0; i < 4; i++) begin
      send_b(8'h02);
      chk(id_s == 1'b0, "R11 no identify from argument", id_s, 0);
    end
    chk(divider == 24'h020202, "R11 argument stored", divider, 24'h020202);

    // back-to-back bytes with gaps mixed in
    send_b(8'h82); @(negedge clk); send_b(8'h3C); send_b(8'h00); @(negedge clk); send_b(8'h00); send_b(8'h00);
    chk(grp_en == 4'h0, "R7 all groups disabled", grp_en, 0);
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule